// File: doc/BRIEF.md
# Block-Transfer Host Register Port

This block is the host-side register window of a block-transfer management channel. It has three byte-wide locations: a control/status register, a data port, and an interrupt mask register. It also holds the request buffer, which the host fills, and the response buffer, which the host drains. Each buffer has its own pointer.

The host uses a simple single-cycle bus made of a two-bit address, read and write strobes, and byte data. Read data is registered.

A neighbouring message engine works with the buffers:
- It reads the request bytes through a random-access port.
- It sees the request length through `rx_len`.
- It is told of a new request by a one-cycle `req_ready` pulse.
- It fills the response buffer through a write port, then marks the response complete with `rsp_done` and a length.

Interrupt generation and message parsing happen outside this block. The mask byte is stored here and passed out as `irq_mask`. The engine-facing ports carry no back-pressure, because every transfer is accepted in the cycle it is presented. The response length must not exceed the buffer depth and is clipped to it.

Top module: `bt_host_port`

## Requirements
- R1: Only `bus_addr` selects a location: 0 is control, 1 is data, 2 is mask. A read of location 3 returns 0xFF, and a write to location 3 changes nothing. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R2: A control read returns controller-busy in bit 7, host-busy in bit 6, event attention in bit 4 and response attention in bit 3. All other bits read 0, and writes to bit 7 have no effect.
- R3: Writing 1 to bit 3 clears response attention, and writing 1 to bit 4 clears event attention. Writing 0 to either bit leaves it unchanged. `rsp_done` sets response attention and `sms_set` sets event attention; a set in the same cycle as a clear wins.
- R4: Writing 1 to control bit 6 toggles host-busy.
- R5: Writing 1 to control bit 2 sets controller-busy and raises `req_ready` for exactly the one cycle after the write.
- R6: A data write stores the byte at index `rx_len` only while `rx_len` is below DEPTH. `rx_len` increments on every data write and saturates at its maximum, so an overrun remains visible and never wraps.
- R7: Writing 1 to control bit 0 zeroes `rx_len`. Writing 1 to control bit 1 rewinds the response read pointer to the first byte.
- R8: A data read returns the next response byte while bytes remain. Reading the last byte returns both the pointer and the length to zero. A data read with nothing pending returns 0xFF.
- R9: The mask location stores all 8 written bits, reads them back, and drives them on `irq_mask`.
- R10: After reset, control and mask read 0x00, `rx_len` is 0, a data read returns 0xFF, and `bus_rdata` is 0x00.
- R11: `rsp_we` writes `rsp_wdata` at `rsp_waddr`. `rsp_done` loads the response length, rewinds the pointer, sets response attention and clears controller-busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Location select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_mask | output | 8 | Stored mask byte for the interrupt block |
| req_ready | output | 1 | One-cycle new-request pulse |
| rx_len | output | CNT_W | Request byte count, saturating |
| req_raddr | input | AW | Request buffer read index |
| req_rdata | output | 8 | Request byte at `req_raddr` |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_waddr | input | AW | Response buffer write index |
| rsp_wdata | input | 8 | Response byte |
| rsp_done | input | 1 | Response complete |
| rsp_len | input | AW+1 | Response length in bytes |
| sms_set | input | 1 | Raise event attention |

## Verification
Some behaviours are checked by properties on every cycle:
- the single-cycle width of the request pulse, and that it coincides with controller-busy;
- the host-busy toggle;
- the write-one-to-clear of response attention;
- the request counter stepping and clearing;
- the self-rewind after the last response byte;
- the 0xFF result for the unused location.

Other behaviours can only be shown by scenarios:
- that bytes beyond capacity never overwrite earlier ones;
- that rewinding mid-message replays the same bytes;
- that writes of 0 leave attention flags alone;
- that a set and a clear arriving together resolve toward the set.

// File: rtl/bt_port_pkg.sv
package bt_port_pkg;
  localparam logic [1:0] LOC_CTRL = 2'd0;
  localparam logic [1:0] LOC_DATA = 2'd1;
  localparam logic [1:0] LOC_MASK = 2'd2;

  localparam int CB_CLR_WR    = 0;
  localparam int CB_CLR_RD    = 1;
  localparam int CB_REQ       = 2;
  localparam int CB_RSP_ATN   = 3;
  localparam int CB_EVT_ATN   = 4;
  localparam int CB_HOST_BUSY = 6;
  localparam int CB_CTL_BUSY  = 7;

  localparam logic [7:0] NO_DATA = 8'hFF;
endpackage

// File: rtl/bt_ctrl_reg.sv
module bt_ctrl_reg
  import bt_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  input  logic       rsp_done,
  input  logic       sms_set,
  output logic [7:0] ctrl_byte,
  output logic       req_ready,
  output logic       clr_wr,
  output logic       clr_rd
);
  logic ctl_busy, host_busy, evt_atn, rsp_atn;

  assign clr_wr = wr_stb & wdata[CB_CLR_WR];
  assign clr_rd = wr_stb & wdata[CB_CLR_RD];

  always_comb begin
    ctrl_byte               = '0;
    ctrl_byte[CB_CTL_BUSY]  = ctl_busy;
    ctrl_byte[CB_HOST_BUSY] = host_busy;
    ctrl_byte[CB_EVT_ATN]   = evt_atn;
    ctrl_byte[CB_RSP_ATN]   = rsp_atn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_busy  <= 1'b0;
      host_busy <= 1'b0;
      evt_atn   <= 1'b0;
      rsp_atn   <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      req_ready <= wr_stb & wdata[CB_REQ];
      if (wr_stb && wdata[CB_REQ])            ctl_busy <= 1'b1;
      else if (rsp_done)                      ctl_busy <= 1'b0;
      if (wr_stb && wdata[CB_HOST_BUSY])      host_busy <= ~host_busy;
      if (rsp_done)                           rsp_atn <= 1'b1;
      else if (wr_stb && wdata[CB_RSP_ATN])   rsp_atn <= 1'b0;
      if (sms_set)                            evt_atn <= 1'b1;
      else if (wr_stb && wdata[CB_EVT_ATN])   evt_atn <= 1'b0;
    end
  end

  AST_HOST_BUSY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[CB_HOST_BUSY]) |=> (ctrl_byte[CB_HOST_BUSY] != $past(ctrl_byte[CB_HOST_BUSY]))); // R4
  AST_RSP_ATN_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[CB_RSP_ATN] && !rsp_done) |=> !ctrl_byte[CB_RSP_ATN]); // R3
  AST_REQ_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ctrl_byte[CB_CTL_BUSY]); // R5
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !(wr_stb && wdata[CB_REQ])) |=> !req_ready); // R5
endmodule

// File: rtl/bt_rx_buf.sv
module bt_rx_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = AW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             clear,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (push && !clear && count < CAP) mem[count[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count <= '0;
    else if (clear)                     count <= '0;
    else if (push && count != CNT_MAX)  count <= count + CNT_W'(1);
  end

  AST_RX_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1))); // R6
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0)); // R7
endmodule

// File: rtl/bt_tx_buf.sv
module bt_tx_buf
  import bt_port_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          ld_done,
  input  logic [AW:0]   ld_len,
  input  logic          pop,
  input  logic          rewind,
  output logic [7:0]    head_byte
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [AW:0] ptr, len;
  logic has;

  assign has       = ptr < len;
  assign head_byte = has ? mem[ptr[AW-1:0]] : NO_DATA;

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      len <= '0;
    end else if (ld_done) begin
      ptr <= '0;
      len <= (ld_len > CAP) ? CAP : ld_len;
    end else if (rewind) begin
      ptr <= '0;
    end else if (pop && has) begin
      if (ptr + (AW+1)'(1) == len) begin
        ptr <= '0;
        len <= '0;
      end else begin
        ptr <= ptr + (AW+1)'(1);
      end
    end
  end

  AST_TX_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && has && !ld_done && (ptr + (AW+1)'(1) == len)) |=> (head_byte == NO_DATA)); // R8
endmodule

// File: rtl/bt_host_port.sv
module bt_host_port
  import bt_port_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [7:0]       irq_mask,
  output logic             req_ready,
  output logic [CNT_W-1:0] rx_len,
  input  logic [AW-1:0]    req_raddr,
  output logic [7:0]       req_rdata,
  input  logic             rsp_we,
  input  logic [AW-1:0]    rsp_waddr,
  input  logic [7:0]       rsp_wdata,
  input  logic             rsp_done,
  input  logic [AW:0]      rsp_len,
  input  logic             sms_set
);
  logic [7:0] ctrl_byte, head_byte;
  logic clr_wr, clr_rd;
  logic ctrl_wr, data_wr, data_rd, mask_wr;

  assign ctrl_wr = bus_wr && bus_addr == LOC_CTRL;
  assign data_wr = bus_wr && bus_addr == LOC_DATA;
  assign mask_wr = bus_wr && bus_addr == LOC_MASK;
  assign data_rd = bus_rd && bus_addr == LOC_DATA;

  bt_ctrl_reg u_ctrl (
    .clk, .rst_n,
    .wr_stb (ctrl_wr), .wdata (bus_wdata),
    .rsp_done, .sms_set,
    .ctrl_byte, .req_ready, .clr_wr, .clr_rd
  );

  bt_rx_buf #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_rx (
    .clk, .rst_n,
    .push (data_wr), .push_data (bus_wdata), .clear (clr_wr),
    .rd_addr (req_raddr), .rd_data (req_rdata), .count (rx_len)
  );

  bt_tx_buf #(.DEPTH(DEPTH), .AW(AW)) u_tx (
    .clk, .rst_n,
    .ld_we (rsp_we), .ld_addr (rsp_waddr), .ld_data (rsp_wdata),
    .ld_done (rsp_done), .ld_len (rsp_len),
    .pop (data_rd), .rewind (clr_rd), .head_byte
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask  <= '0;
      bus_rdata <= '0;
    end else begin
      if (mask_wr) irq_mask <= bus_wdata;
      if (bus_rd) begin
        case (bus_addr)
          LOC_CTRL: bus_rdata <= ctrl_byte;
          LOC_DATA: bus_rdata <= head_byte;
          LOC_MASK: bus_rdata <= irq_mask;
          default:  bus_rdata <= NO_DATA;
        endcase
      end
    end
  end

  AST_UNUSED_LOC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == NO_DATA)); // R1
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(irq_mask)); // R9
endmodule

// File: tb/test_bt_host_port.sv
`timescale 1ns/100ps
module test_bt_host_port;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, irq_mask, req_rdata;
  logic req_ready;
  logic [CNT_W-1:0] rx_len;
  logic [AW-1:0] req_raddr = '0;
  logic rsp_we = 1'b0;
  logic [AW-1:0] rsp_waddr = '0;
  logic [7:0] rsp_wdata = '0;
  logic rsp_done = 1'b0;
  logic [AW:0] rsp_len = '0;
  logic sms_set = 1'b0;

  int applied = 0;
  int bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  bt_host_port #(.DEPTH(DEPTH)) i_bt_host_port (.*);

  // entry: {is_read, addr[1:0], wdata[7:0], expect[7:0]}
  localparam int NV = 21;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 8'h00},  // R10 control after reset
    {1'b1, 2'd2, 8'h00, 8'h00},  // R10 mask after reset
    {1'b1, 2'd1, 8'h00, 8'hFF},  // R8 empty data read
    {1'b1, 2'd3, 8'h00, 8'hFF},  // R1 unused location
    {1'b0, 2'd2, 8'hA5, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hA5},  // R9
    {1'b0, 2'd3, 8'h5A, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hA5},  // R1 write to 3 ignored
    {1'b1, 2'd0, 8'h00, 8'h00},  // R1
    {1'b0, 2'd0, 8'h40, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h40},  // R4 toggle on
    {1'b0, 2'd0, 8'h40, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h00},  // R4 toggle off
    {1'b0, 2'd0, 8'h18, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h00},  // R3 clear of clear flags
    {1'b0, 2'd0, 8'h04, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h80},  // R5 busy set
    {1'b0, 2'd0, 8'hC8, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'hC0},  // R2 bit7 write no effect, bit6 toggles
    {1'b0, 2'd0, 8'h40, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h80}   // R2 layout
  };
  localparam string VTAG [NV] = '{"R10","R10","R8","R1","-","R9","-","R1","R1","-",
                                  "R4","-","R4","-","R3","-","R5","-","R2","-","R2"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rsp_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); rsp_waddr = a; rsp_wdata = d; rsp_we = 1'b1;
    @(negedge clk); rsp_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 bus_rdata", 32'(bus_rdata), 32'h00);
    chk("R10 rx_len", 32'(rx_len), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        brd(VEC[i][17:16], rv);
        chk(VTAG[i], 32'(rv), 32'(VEC[i][7:0]));
      end else begin
        bwr(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R5 pulse lasts one cycle after the write
    bwr(2'd0, 8'h04);
    chk("R5 req_ready high", 32'(req_ready), 1);
    @(negedge clk);
    chk("R5 req_ready low", 32'(req_ready), 0);

    // R6 request bytes
    bwr(2'd0, 8'h01);
    bwr(2'd1, 8'h11); bwr(2'd1, 8'h22); bwr(2'd1, 8'h33);
    chk("R6 rx_len", 32'(rx_len), 3);
    req_raddr = 1; #1;
    chk("R6 stored byte", 32'(req_rdata), 32'h22);
    bwr(2'd0, 8'h01);
    chk("R7 clear write count", 32'(rx_len), 0);

    // R6 overrun: bytes past capacity are counted, not stored
    for (int i = 0; i < DEPTH + 2; i++) bwr(2'd1, 8'(8'h80 + i));
    chk("R6 overrun count", 32'(rx_len), DEPTH + 2);
    req_raddr = 0; #1;
    chk("R6 no wrap first", 32'(req_rdata), 32'h80);
    req_raddr = AW'(DEPTH - 1); #1;
    chk("R6 last stored", 32'(req_rdata), 32'(8'h80 + DEPTH - 1));

    // R11 response load
    rsp_byte(0, 8'hAA); rsp_byte(1, 8'hBB); rsp_byte(2, 8'hCC);
    @(negedge clk); rsp_len = 3; rsp_done = 1'b1;
    @(negedge clk); rsp_done = 1'b0;
    brd(2'd0, rv); chk("R11 attn set busy cleared", 32'(rv), 32'h08);
    brd(2'd1, rv); chk("R8 byte0", 32'(rv), 32'hAA);
    brd(2'd1, rv); chk("R8 byte1", 32'(rv), 32'hBB);
    bwr(2'd0, 8'h02);
    brd(2'd1, rv); chk("R7 rewind byte0", 32'(rv), 32'hAA);
    brd(2'd1, rv); chk("R8 byte1 again", 32'(rv), 32'hBB);
    brd(2'd1, rv); chk("R8 last byte", 32'(rv), 32'hCC);
    brd(2'd1, rv); chk("R8 empty after last", 32'(rv), 32'hFF);
    bwr(2'd0, 8'h02);
    brd(2'd1, rv); chk("R8 length zeroed", 32'(rv), 32'hFF);

    // R3 attention clears and sets
    bwr(2'd0, 8'h08);
    brd(2'd0, rv); chk("R3 rsp attn cleared", 32'(rv), 32'h00);
    @(negedge clk); sms_set = 1'b1;
    @(negedge clk); sms_set = 1'b0;
    brd(2'd0, rv); chk("R3 event attn set", 32'(rv), 32'h10);
    bwr(2'd0, 8'h00);
    brd(2'd0, rv); chk("R3 zero write no effect", 32'(rv), 32'h10);
    bwr(2'd0, 8'h10);
    brd(2'd0, rv); chk("R3 event attn cleared", 32'(rv), 32'h00);
    // set and clear together: set wins
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h08; bus_wr = 1'b1;
    rsp_len = 0; rsp_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; rsp_done = 1'b0;
    brd(2'd0, rv); chk("R3 set wins", 32'(rv), 32'h08);

    chk("R9 irq_mask port", 32'(irq_mask), 32'hA5);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule